// File: doc/BRIEF.md
# Synchronous burst SRAM access controller

This block is the control core of a synchronous flow-through memory with a shared data bus. On each rising clock edge it decides whether the cycle is a new access, a continuation of the running access, or a deselect. It holds the access address and applies the global and per-lane write enables to a small internal array that is organised in byte lanes. A byte lane is eight data bits plus one parity bit.

A new access starts on one of two address strobes. A processor strobe always opens a read, and any write follows on a later clock. A controller strobe can write in the same clock. A separate burst generator supplies the next address. The block takes that address on continuation cycles that have the advance input low. Read data flows straight from the array at the held address. The block also produces the drive enable for the external tri-state data pins. That enable combines the asynchronous output enable with several cycle-state masks.

Top module: `sbsram_ctrl`

## Requirements
- R1: A load cycle selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at that edge; any other combination deselects it. On continuation cycles the three chip enables are ignored.
- R2: A processor strobe (`adsp_n`=0 with `ce1_n`=0) loads `addr_i` and starts a read. The write inputs are ignored at that edge, and the strobe takes priority over `adsc_n`.
- R3: When `ce1_n`=1, `adsp_n` is ignored. The cycle is then governed by `adsc_n` if it is low, and is otherwise a continuation.
- R4: A controller strobe (`adsc_n`=0, processor strobe not taken) with the device selected and a write request writes `dq_i` at `addr_i` on that same edge.
- R5: A continuation cycle (no strobe taken, device selected) with a write request writes `dq_i` at the held address. When `adv_n`=0 it writes at `burst_addr_i` instead, and that address becomes the held address.
- R6: With `gw_n`=0 all lanes are written, whatever `bwe_n` and `bw_n` are.
- R7: With `gw_n`=1, lane i (bits [9i+8:9i], parity bit at 9i+8) is written only when `bwe_n`=0 and `bw_n[i]`=0. `bwe_n`=1 writes nothing. A write request is `gw_n`=0, or `bwe_n`=0 with at least one `bw_n` bit low.
- R8: `dq_o` shows the array word at the held address, without any clock delay, in the cycle after the access edge.
- R9: `dq_oe` is high only in a selected read cycle that is not the first cycle after leaving the deselected state, and only while `oe_n`=0. `oe_n` acts without a clock. `dq_oe` is low in the cycle after any write edge.
- R10: A synchronous active-high `rst` deselects the device, so `dq_oe` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | External address, taken on a strobe |
| burst_addr_i | input | ADDR_W | Next address from the burst generator |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data from the pins |
| dq_o | output | LANES*LANE_W | Read data to the pins |
| dq_oe | output | 1 | Pin drive enable |

## Verification
If the select or first-cycle state is wrong, `dq_oe` takes the wrong value in the cycle right after the edge that updated it. If the held address is wrong, `dq_o` differs from the expected word in that same cycle. A write steered to the wrong address or lane stays hidden until that location is read back. The bench therefore reads back after directed writes, and its random phase compares every driven read against a reference array.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode (
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  input  logic sel_q,
  output logic load,
  output logic c_take,
  output logic chip_on,
  output logic cont
);
  logic p_take;

  // processor strobe only counts with ce1_n low, and then wins over adsc_n
  assign p_take  = !adsp_n && !ce1_n;
  assign c_take  = !adsc_n && !p_take;
  assign load    = p_take || c_take;
  assign chip_on = !ce1_n && ce2 && !ce3_n;
  assign cont    = !load && sel_q;
endmodule

// File: rtl/sbsram_wmask.sv
module sbsram_wmask #(
  parameter int LANES = 4
) (
  input  logic             wr_go,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_go && (!gw_n || (!bwe_n && !bw_n[i]));
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-1:0]       burst_addr_i,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);
  import sbsram_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic              load, c_take, chip_on, cont, wr_go;
  logic              sel_q, first_q;
  cyc_e              cyc_q;
  logic [ADDR_W-1:0] addr_q, acc_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;

  sbsram_decode u_dec (
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .sel_q  (sel_q),
    .load   (load),
    .c_take (c_take),
    .chip_on(chip_on),
    .cont   (cont)
  );

  // writes allowed on a selecting controller strobe or on a continuation
  assign wr_go = (c_take && chip_on) || cont;

  sbsram_wmask #(.LANES(LANES)) u_wm (
    .wr_go  (wr_go),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .lane_we(lane_we)
  );

  always_comb begin
    if (load)        acc_addr = addr_i;
    else if (!adv_n) acc_addr = burst_addr_i;
    else             acc_addr = addr_q;
  end

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk  (clk),
    .we   (lane_we),
    .waddr(acc_addr),
    .wdata(dq_i),
    .raddr(addr_q),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      first_q <= 1'b0;
      cyc_q   <= CYC_IDLE;
      addr_q  <= '0;
    end else if (load) begin
      if (chip_on) begin
        sel_q   <= 1'b1;
        first_q <= !sel_q;
        addr_q  <= addr_i;
        cyc_q   <= (|lane_we) ? CYC_WRITE : CYC_READ;
      end else begin
        sel_q   <= 1'b0;
        first_q <= 1'b0;
        cyc_q   <= CYC_IDLE;
      end
    end else if (sel_q) begin
      first_q <= 1'b0;
      addr_q  <= acc_addr;
      cyc_q   <= (|lane_we) ? CYC_WRITE : CYC_READ;
    end
  end

  assign dq_o  = rdata;
  assign dq_oe = (cyc_q == CYC_READ) && !first_q && !oe_n;
endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             adsp_n,
  input logic             ce1_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic [LANES-1:0] lane_we,
  input logic             wr_go,
  input logic             sel_q,
  input logic             chip_on,
  input logic             load
);
  a_r10_reset_quiet: assert property (@(posedge clk) rst |=> !dq_oe);

  a_r1_deselect: assert property (@(posedge clk) disable iff (rst)
    (load && !chip_on) |=> !dq_oe);

  a_r2_adsp_no_write: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce1_n) |-> (lane_we == '0));

  a_r6_global_all: assert property (@(posedge clk) disable iff (rst)
    (wr_go && !gw_n) |-> (&lane_we));

  a_r7_bwe_gate: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |-> (lane_we == '0));

  a_r9_first_mask: assert property (@(posedge clk) disable iff (rst)
    (load && chip_on && !sel_q) |=> !dq_oe);

  a_r9_write_phase: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |=> !dq_oe);

  a_r9_oe_gate: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);
endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .adsp_n (adsp_n),
  .ce1_n  (ce1_n),
  .gw_n   (gw_n),
  .bwe_n  (bwe_n),
  .oe_n   (oe_n),
  .dq_oe  (dq_oe),
  .lane_we(lane_we),
  .wr_go  (wr_go),
  .sel_q  (sel_q),
  .chip_on(chip_on),
  .load   (load)
);

// File: tb/tb_sbsram_ctrl.sv
`timescale 1ns/1ps
module tb_sbsram_ctrl;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0, burst_addr_i = '0;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe;

  sbsram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [1<<AW];
  logic          m_sel = 0, m_rd = 0, m_first = 0;
  logic [AW-1:0] m_addr = '0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, ~a[0], a ^ 8'hA5, a[1], ~a, a[2], a + 8'd3, a[3]};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0;
  endtask

  // one clock: reference update from the requirements, then output check
  task automatic tick(input string tag);
    logic p, c, ld, on, go;
    logic [AW-1:0] a;
    logic [NL-1:0] m;
    @(posedge clk);
    p  = !adsp_n && !ce1_n;
    c  = !adsc_n && !p;
    ld = p || c;
    on = !ce1_n && ce2 && !ce3_n;
    go = (c && on) || (!ld && m_sel);
    a  = ld ? addr_i : (!adv_n ? burst_addr_i : m_addr);
    for (int i = 0; i < NL; i++) begin
      m[i] = go && (!gw_n || (!bwe_n && !bw_n[i]));
      if (m[i]) ref_mem[a][i*LW +: LW] = dq_i[i*LW +: LW];
    end
    if (ld) begin
      if (on) begin
        m_first = !m_sel; m_sel = 1; m_addr = addr_i; m_rd = !(|m);
      end else begin
        m_sel = 0; m_rd = 0; m_first = 0;
      end
    end else if (m_sel) begin
      m_addr = a; m_first = 0; m_rd = !(|m);
    end
    #2;
    chk({tag, " R9 drive"}, {35'd0, dq_oe}, {35'd0, m_sel && m_rd && !m_first && !oe_n});
    if (m_sel && m_rd && !m_first && !oe_n) chk({tag, " R8 data"}, dq_o, ref_mem[m_addr]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d1, d2, d3;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(posedge clk); #2;
    chk("R10 reset", {35'd0, dq_oe}, '0);

    // R4: fill the array with controller-strobe global writes
    for (int a = 0; a < (1 << AW); a++) begin
      idle(); adsc_n = 0; addr_i = a[AW-1:0]; gw_n = 0; dq_i = pat(a[AW-1:0]);
      tick("R4 fill");
    end

    // R1: load with ce2 low deselects
    idle(); adsc_n = 0; ce2 = 0; tick("R1");
    chk("R1 deselect", {35'd0, dq_oe}, '0);
    idle(); tick("R1 idle");

    // R9: first read cycle after deselect is masked
    idle(); adsp_n = 0; addr_i = 8'd10; tick("R9");
    chk("R9 first masked", {35'd0, dq_oe}, '0);
    idle(); tick("R8");
    chk("R8 read data", dq_o, pat(8'd10));

    // R2: processor strobe ignores write inputs
    idle(); adsp_n = 0; addr_i = 8'd20; gw_n = 0; dq_i = '0; tick("R2");
    chk("R2 no write on adsp", dq_o, pat(8'd20));

    // R5: write on next clock after processor strobe
    d1 = 36'h9_8765_4321;
    idle(); gw_n = 0; dq_i = d1; tick("R5");
    chk("R9 write phase", {35'd0, dq_oe}, '0);
    idle(); tick("R5 rd");
    chk("R5 follow-on write", dq_o, d1);

    // R7: byte lanes 0 and 2 only, parity bits included
    idle(); adsc_n = 0; addr_i = 8'd30; bwe_n = 0; bw_n = 4'b1010; dq_i = '1; tick("R7");
    idle(); tick("R7 rd");
    chk("R7 lane mask", dq_o, pat(8'd30) | 36'h0_07FC_01FF);

    // R6: global write overrides lane selects
    idle(); adsc_n = 0; addr_i = 8'd31; gw_n = 0; bwe_n = 0; bw_n = '1; dq_i = 36'h1_2345_6789;
    tick("R6");
    idle(); tick("R6 rd");
    chk("R6 global write", dq_o, 36'h1_2345_6789);

    // R7: bwe_n high means no write
    idle(); adsc_n = 0; addr_i = 8'd32; bw_n = '0; dq_i = '0; tick("R7b");
    chk("R7 bwe off", dq_o, pat(8'd32));

    // R1: chip enables ignored on continuation
    idle(); ce2 = 0; ce3_n = 1; tick("R1b");
    chk("R1 continue drive", {35'd0, dq_oe}, 36'd1);
    chk("R1 continue data", dq_o, pat(8'd32));

    // R1: write with ce3_n high is dropped
    idle(); adsc_n = 0; addr_i = 8'd40; ce3_n = 1; gw_n = 0; dq_i = '0; tick("R1c");
    chk("R1 bad ce deselect", {35'd0, dq_oe}, '0);
    idle(); adsc_n = 0; addr_i = 8'd40; tick("R1d");
    idle(); tick("R1e");
    chk("R1 no write when deselected", dq_o, pat(8'd40));

    // R5: burst write at the generator address
    d2 = 36'hA_BCDE_F012;
    idle(); adsc_n = 0; addr_i = 8'd50; tick("R5b");
    idle(); adv_n = 0; burst_addr_i = 8'd51; gw_n = 0; dq_i = d2; tick("R5c");
    idle(); tick("R5d");
    chk("R5 burst write", dq_o, d2);

    // R9: asynchronous output enable
    idle(); oe_n = 1; tick("R9b");
    chk("R9 oe high", {35'd0, dq_oe}, '0);
    #1 oe_n = 0; #1;
    chk("R9 oe async", {35'd0, dq_oe}, 36'd1);

    // R3: adsp_n ignored with ce1_n high, continuation writes
    d3 = 36'h5_5AA5_3CC3;
    idle(); adsc_n = 0; addr_i = 8'd60; tick("R3a");
    idle(); ce1_n = 1; adsp_n = 0; gw_n = 0; dq_i = d3; tick("R3b");
    idle(); tick("R3c");
    chk("R3 adsp ignored", dq_o, d3);
    // R3: adsc with ce1_n high deselects
    idle(); ce1_n = 1; adsp_n = 0; adsc_n = 0; tick("R3d");
    chk("R3 adsc deselect", {35'd0, dq_oe}, '0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      adsp_n = ($urandom % 5) != 0;
      adsc_n = ($urandom % 5) != 0;
      adv_n  = $urandom % 2;
      ce1_n  = ($urandom % 8) == 0;
      ce2    = ($urandom % 8) != 0;
      ce3_n  = ($urandom % 8) == 0;
      gw_n   = ($urandom % 5) != 0;
      bwe_n  = ($urandom % 5) < 3;
      bw_n   = NL'($urandom);
      oe_n   = ($urandom % 5) == 0;
      addr_i = AW'($urandom);
      burst_addr_i = AW'($urandom);
      dq_i   = {4'($urandom), 32'($urandom)};
      tick("rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule